// File: doc/BRIEF.md
# Serial Bit-Rate Calibration and Handshake Unit

This unit sits on the receive wire of an asynchronous serial link and works out the remote host's bit rate from one calibration character. The host sends a zero byte. Its start bit and its eight zero data bits form one unbroken low stretch of nine bit times. The unit counts the system clocks in that stretch and divides the count by nine, rounding to the nearest integer. The result is the number of clocks per bit, which the unit keeps as its divisor.

With that divisor the unit checks that the line stays idle for one bit time. It then sends an acknowledge byte of value zero and waits for the host's confirmation byte 0x55. A correct confirmation raises `done`. A wrong value, a missing stop bit, or a line that drops too early after the calibration stretch raises `error`. Either flag holds until reset or a new `start`, because the unit never retries on its own.

Frames use one start bit, eight data bits sent LSB first, one stop bit and no parity. The default counter width covers the slowest supported rate at the fastest supported clock: 2400 bit/s at 16 MHz gives about 60,000 clocks for nine bits.

Top module: `autobaud_hs`

## Requirements
- R1: After synchronous reset, `tx` is 1 and `busy`, `done`, `error` and `divisor` are all 0.
- R2: A `start` pulse while `busy` is 0 sets `busy`, clears `done`, `error` and `divisor`, and arms the measurement. A `start` pulse while `busy` is 1 has no effect.
- R3: For an armed unit that sees a low stretch of L clocks on `rx`, `divisor` becomes floor((L+4)/9) once the line returns high. For example, L=364 gives 40 and L=365 gives 41.
- R4: A low pulse shorter than GLITCH_MIN clocks (default 16) is ignored. `divisor` stays 0 and the unit keeps waiting for the calibration stretch.
- R5: After the divisor is latched, `rx` must stay high for `divisor` clocks. A low level before then sets `error` and clears `busy`.
- R6: The unit then sends byte 0x00 on `tx`: a low start bit, eight data bits LSB first, and a high stop bit, each bit lasting `divisor` clocks.
- R7: After the acknowledge, a reply frame is sampled at mid-bit from its start-bit falling edge. If the data is 0x55 and the stop bit is high, `done` goes to 1 and `busy` goes to 0.
- R8: A reply whose data is not 0x55, or whose stop bit is low, sets `error` and clears `busy`. Later `rx` activity changes neither `error` nor `divisor`.
- R9: The measurement counter holds a low stretch of 60,003 clocks without overflow, giving a divisor of 6667.
- R10: `done` and `error` are never 1 together, and `tx` is 1 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new calibration session |
| rx | input | 1 | Serial receive line from the host (asynchronous) |
| tx | output | 1 | Serial transmit line to the host |
| divisor | output | CNT_W | Derived clocks-per-bit value |
| done | output | 1 | Handshake completed correctly |
| error | output | 1 | Calibration or handshake failed |
| busy | output | 1 | Session in progress |

## Verification
The hardest cases to reach from the ports are the rounding boundary of the divide-by-nine and the reply frame. The rounding can only be seen by placing a low stretch exactly one clock either side of a half-bit. The reply frame only counts when it is timed to the divisor the unit has just derived. The bench therefore drives low stretches of 364 and 365 clocks. It decodes the acknowledge at the derived rate and answers at that same rate, using either a correct byte, a wrong byte or a byte with a low stop bit. Separate runs cover a short glitch before calibration, an early drop after it, and a stretch of 60,003 clocks.

// File: rtl/abd_pkg.sv
package abd_pkg;

    localparam logic [7:0] ACK_BYTE   = 8'h00;
    localparam logic [7:0] REPLY_BYTE = 8'h55;
    localparam int         FRAME_BITS = 10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_MEAS,
        S_STOP,
        S_ACK,
        S_RPLY,
        S_DONE,
        S_FAIL
    } abd_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_ok;
    } rx_frame_t;

    // nearest-integer quotient of n / 9
    function automatic logic [31:0] round_div9(input logic [31:0] n);
        return (n + 32'd4) / 32'd9;
    endfunction

endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sr <= '1;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/abd_uart_tx.sv
module abd_uart_tx
    import abd_pkg::*;
#(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [7:0]   data,
    input  logic [W-1:0] bit_len,
    output logic         tx,
    output logic         fin
);
    localparam int BW = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [BW-1:0]         bits_left;
    logic [W-1:0]          tick;
    logic                  active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '1;
            bits_left <= '0;
            tick      <= '0;
            active    <= 1'b0;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!active) begin
                if (go) begin
                    shreg     <= {1'b1, data, 1'b0};
                    bits_left <= BW'(FRAME_BITS);
                    tick      <= bit_len - 1'b1;
                    active    <= 1'b1;
                end
            end else if (tick == '0) begin
                shreg     <= {1'b1, shreg[FRAME_BITS-1:1]};
                bits_left <= bits_left - 1'b1;
                tick      <= bit_len - 1'b1;
                if (bits_left == BW'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end else begin
                tick <= tick - 1'b1;
            end
        end
    end

    assign tx = !active | shreg[0];
endmodule

// File: rtl/abd_uart_rx.sv
module abd_uart_rx
    import abd_pkg::*;
#(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         rx,
    input  logic [W-1:0] bit_len,
    output logic         valid,
    output rx_frame_t    frame
);
    logic [W-1:0] tick;
    logic [3:0]   idx;
    logic         run;
    logic [7:0]   shift;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tick  <= '0;
            idx   <= '0;
            run   <= 1'b0;
            shift <= '0;
            valid <= 1'b0;
            frame <= '0;
        end else begin
            valid <= 1'b0;
            if (!run) begin
                if (!rx) begin
                    run  <= 1'b1;
                    idx  <= '0;
                    tick <= (bit_len >> 1) - 1'b1;
                end
            end else if (tick == '0) begin
                tick <= bit_len - 1'b1;
                idx  <= idx + 1'b1;
                if (idx == 4'd0) begin
                    if (rx) run <= 1'b0;          // false start
                end else if (idx <= 4'd8) begin
                    shift <= {rx, shift[7:1]};
                end else begin
                    frame.data     <= shift;
                    frame.frame_ok <= rx;
                    valid          <= 1'b1;
                    run            <= 1'b0;
                end
            end else begin
                tick <= tick - 1'b1;
            end
        end
    end
endmodule

// File: rtl/autobaud_hs.sv
module autobaud_hs
    import abd_pkg::*;
#(
    parameter int CNT_W      = 17,
    parameter int GLITCH_MIN = 16,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rx,
    output logic             tx,
    output logic [CNT_W-1:0] divisor,
    output logic             done,
    output logic             error,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] GL_MIN  = CNT_W'(GLITCH_MIN);

    abd_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             rx_s;
    logic             tx_go;
    logic             tx_fin;
    logic             rx_valid;
    rx_frame_t        rx_frame;

    abd_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst(rst), .d(rx), .q(rx_s)
    );

    abd_uart_tx #(.W(CNT_W)) u_tx (
        .clk(clk), .rst(rst), .go(tx_go), .data(ACK_BYTE),
        .bit_len(divisor), .tx(tx), .fin(tx_fin)
    );

    abd_uart_rx #(.W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .en(state == S_RPLY), .rx(rx_s),
        .bit_len(divisor), .valid(rx_valid), .frame(rx_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cnt     <= '0;
            divisor <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
            tx_go   <= 1'b0;
        end else begin
            tx_go <= 1'b0;
            unique case (state)
                S_IDLE, S_DONE, S_FAIL: begin
                    if (start) begin
                        state   <= S_ARM;
                        done    <= 1'b0;
                        error   <= 1'b0;
                        divisor <= '0;
                    end
                end
                S_ARM: begin
                    if (!rx_s) begin
                        cnt   <= CNT_W'(1);
                        state <= S_MEAS;
                    end
                end
                S_MEAS: begin
                    if (!rx_s) begin
                        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    end else if (cnt < GL_MIN) begin
                        state <= S_ARM;
                    end else begin
                        divisor <= CNT_W'(round_div9(32'(cnt)));
                        cnt     <= CNT_W'(1);
                        state   <= S_STOP;
                    end
                end
                S_STOP: begin
                    if (!rx_s) begin
                        error <= 1'b1;
                        state <= S_FAIL;
                    end else if (cnt >= divisor) begin
                        tx_go <= 1'b1;
                        state <= S_ACK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_ACK: begin
                    if (tx_fin) state <= S_RPLY;
                end
                S_RPLY: begin
                    if (rx_valid) begin
                        if (rx_frame.data == REPLY_BYTE && rx_frame.frame_ok) begin
                            done  <= 1'b1;
                            state <= S_DONE;
                        end else begin
                            error <= 1'b1;
                            state <= S_FAIL;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy = !(state == S_IDLE || state == S_DONE || state == S_FAIL);
endmodule

// File: rtl/autobaud_hs_chk.sv
module autobaud_hs_chk #(
    parameter int CNT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             tx,
    input logic [CNT_W-1:0] divisor,
    input logic             done,
    input logic             error,
    input logic             busy
);
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !error && tx && divisor == '0));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !error));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    p_tx_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    p_end_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy);

    p_div_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ((done || error) && !$past(start)) |=> $stable(divisor) || $past(start));
endmodule

bind autobaud_hs autobaud_hs_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_autobaud_hs.sv
module test_autobaud_hs;
    localparam int CNT_W = 17;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             rx = 1'b1;
    logic             tx;
    logic [CNT_W-1:0] divisor;
    logic             done, error, busy;

    int checks = 0;
    int bad = 0;

    // reference model state
    bit mdl_div_known = 1'b0;
    int mdl_div = 0;

    always #2 clk = ~clk;

    autobaud_hs #(.CNT_W(CNT_W)) i_autobaud_hs (
        .clk(clk), .rst(rst), .start(start), .rx(rx), .tx(tx),
        .divisor(divisor), .done(done), .error(error), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (done && error) begin
                bad++; $display("FAIL R10 actual=done&error expected=exclusive");
            end else if (!busy && !tx) begin
                bad++; $display("FAIL R10 actual=tx 0 expected=1 while idle");
            end else if (mdl_div_known && int'(divisor) != mdl_div) begin
                bad++; $display("FAIL R3 actual=%0d expected=%0d", divisor, mdl_div);
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic drive_low(input int len);
        rx = 1'b0;
        repeat (len) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input int d, input bit stop_hi);
        rx = 1'b0;
        repeat (d) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (d) @(negedge clk);
        end
        rx = stop_hi;
        repeat (d) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic get_ack(input int d, output logic [7:0] b, output bit stop_ok);
        int guard = 0;
        while (tx && guard < 4 * d + 100) begin
            @(negedge clk); guard++;
        end
        repeat (d / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (d) @(negedge clk);
            b[i] = tx;
        end
        repeat (d) @(negedge clk);
        stop_ok = tx;
        repeat (d) @(negedge clk);
    endtask

    task automatic calibrate(input int len, input int exp_d);
        mdl_div_known = 1'b0;
        drive_low(len);
        repeat (6) @(negedge clk);
        check(int'(divisor) == exp_d, "R3", int'(divisor), exp_d);
        mdl_div = exp_d;
        mdl_div_known = 1'b1;
    endtask

    initial begin
        logic [7:0] ab;
        bit so;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx && !busy && !done && !error && divisor == '0, "R1", {busy, done, error}, 0);

        // session 1: glitch, calibrate, good handshake
        pulse_start();
        mdl_div = 0; mdl_div_known = 1'b1;
        check(busy && !done && !error, "R2", busy, 1);
        drive_low(5);
        repeat (10) @(negedge clk);
        check(divisor == '0 && busy, "R4", int'(divisor), 0);
        calibrate(360, 40);
        get_ack(40, ab, so);
        check(ab == 8'h00 && so, "R6", ab, 0);
        pulse_start();
        check(busy && !done, "R2 start ignored while busy", busy, 1);
        repeat (40) @(negedge clk);
        send_byte(8'h55, 40, 1'b1);
        repeat (80) @(negedge clk);
        check(done && !error && !busy, "R7", {done, error, busy}, 4);

        // session 2: round-down boundary, wrong reply
        pulse_start();
        mdl_div = 0;
        check(!done && !error && busy && divisor == '0, "R2 flags cleared", {done, error}, 0);
        calibrate(364, 40);
        get_ack(40, ab, so);
        check(ab == 8'h00 && so, "R6", ab, 0);
        repeat (40) @(negedge clk);
        send_byte(8'h54, 40, 1'b1);
        repeat (80) @(negedge clk);
        check(error && !done && !busy, "R8 wrong value", {done, error, busy}, 2);
        send_byte(8'h55, 40, 1'b1);
        drive_low(400);
        repeat (20) @(negedge clk);
        check(error && !done && int'(divisor) == 40, "R8 held", int'(divisor), 40);

        // session 3: round-up boundary, low stop bit in reply
        pulse_start();
        calibrate(365, 41);
        get_ack(41, ab, so);
        check(ab == 8'h00 && so, "R6 at 41", ab, 0);
        repeat (41) @(negedge clk);
        send_byte(8'h55, 41, 1'b0);
        repeat (80) @(negedge clk);
        check(error && !done && !busy, "R8 framing", {done, error, busy}, 2);

        // session 4: line drops before a full idle bit
        pulse_start();
        calibrate(360, 40);
        repeat (10) @(negedge clk);
        drive_low(50);
        repeat (10) @(negedge clk);
        check(error && !busy && tx, "R5", {error, busy}, 2);

        // session 5: longest stretch
        pulse_start();
        calibrate(60003, 6667);
        check(int'(divisor) == 6667, "R9", int'(divisor), 6667);
        mdl_div_known = 1'b0;
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(tx && !busy && !done && !error && divisor == '0, "R1 again", int'(divisor), 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule